// File: doc/BRIEF.md
# Period Timer with Compare-Driven Restart

This block is a 16-bit up-counter for a peripheral subsystem. The counter advances by one on each clock where the block is running and the count-tick input is high. When it wraps from its top value to zero, it sets a sticky overflow flag, and it drives an interrupt line when that flag and an interrupt-enable bit are both set. Software reaches the block through a byte-wide write port. The port loads the counter as two bytes, sets the compare register, picks a compare mode and writes a control byte.

The compare register holds a 16-bit value. When the mode field selects special-event operation, a step taken while the count equals the compare value is a match. A match sends the counter back to zero instead of incrementing it, so the compare register sets the period (N gives N+1 steps). A match also emits a one-cycle trigger pulse. A second one-cycle pulse, gated by a converter-enable input, tells an external converter to start. A match reset never sets the overflow flag. A counter load written in the same cycle as a match takes precedence over the reset.

Run control is a two-state machine. In ST_HALT the counter holds. In ST_RUN each tick is a step. A control write with the run bit set moves ST_HALT to ST_RUN (transition GO). A control write with the run bit clear moves ST_RUN to ST_HALT (transition STOP). Any other cycle keeps the current state. In each cycle the counter takes one of five actions, in falling priority: LOAD on a low-byte write, EVT on a match, WRAP on a step at 0xFFFF, STEP on any other step, and otherwise HOLD.

Top module: `cmp_timer`

## Requirements
- R1: After a synchronous active-high reset, the count, overflow flag, interrupt, trigger and converter-start outputs are all 0. The compare register, mode field, interrupt enable, high-byte buffer and run state (ST_HALT) are also cleared.
- R2: The count increases by exactly one on a clock edge where the run state is ST_RUN and the tick input is high. Otherwise it is unchanged, unless a load or a match acts on it.
- R3: A step at 0xFFFF gives 0x0000 and sets the overflow flag. The flag stays set until a control write (address 4) carries 1 in bit 2. When a wrap and that clear happen in the same cycle, the flag is set.
- R4: The interrupt output is high exactly when the overflow flag is set and the interrupt-enable bit (address 4, bit 1) is set.
- R5: With mode field value 4'b1011 (address 5, bits 3:0), a step taken while the count equals the compare register makes the next count 0x0000 and raises the trigger output for that one cycle. The period is therefore compare value + 1 steps.
- R6: A match reset never sets the overflow flag, including a match at compare value 0xFFFF.
- R7: A low-byte counter write in the same cycle as a match, a wrap or a step loads the written value. The match reset, the wrap and the flag setting are all skipped in that cycle.
- R8: The converter-start output pulses for one cycle together with each trigger pulse, and only while the converter-enable input was high in the matching cycle.
- R9: A write to address 1 stores a high byte in a buffer without changing the count. A write to address 0 loads {buffer, written byte} in one step. The buffer keeps its value across later loads.
- R10: Writes to address 2 and address 3 set the low and high bytes of the compare register. With any mode value other than 4'b1011, an equal count does not reset the counter.
- R11: A control write (address 4) with bit 0 = 1 performs GO to ST_RUN. With bit 0 = 0 it performs STOP to ST_HALT. In ST_HALT, ticks do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-tick qualifier |
| conv_en_i | input | 1 | Enables the converter-start pulse |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Register select: 0 count low, 1 count high, 2 compare low, 3 compare high, 4 control, 5 mode |
| wr_data_i | input | 8 | Write data byte |
| count_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |
| trig_o | output | 1 | One-cycle special-event trigger |
| conv_start_o | output | 1 | One-cycle converter-start pulse |

## Verification
A wrong run state or action choice appears on count_o at the very next clock edge, as a missed, extra or wrongly reset step. The reference model compares the count every cycle, so such an error is caught within one cycle. A corrupted compare register or mode field shows up only when the count reaches the period boundary. For that reason each compare scenario runs through several full periods and counts the trigger pulses. A wrong flag update shows at once on ovf_flag_o and, when the interrupt enable is set, on irq_o.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        A_CNT_LO = 3'd0,
        A_CNT_HI = 3'd1,
        A_CMP_LO = 3'd2,
        A_CMP_HI = 3'd3,
        A_CTRL   = 3'd4,
        A_MODE   = 3'd5
    } reg_addr_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    typedef enum logic [2:0] {
        NX_HOLD = 3'd0,
        NX_STEP = 3'd1,
        NX_WRAP = 3'd2,
        NX_EVT  = 3'd3,
        NX_LOAD = 3'd4
    } cnt_nx_e;

    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_SPECIAL = 4'b1011;

    localparam int CTRL_RUN = 0;
    localparam int CTRL_IE  = 1;
    localparam int CTRL_CLR = 2;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                wr_en_i,
    input  logic [2:0]          wr_addr_i,
    input  logic [DW-1:0]       wr_data_i,
    output logic                lo_wr_o,
    output logic                ctrl_wr_o,
    output logic                run_bit_o,
    output logic                clr_req_o,
    output logic                ie_o,
    output logic [DW-1:0]       hi_buf_o,
    output logic [2*DW-1:0]     cmp_o,
    output logic [MODE_W-1:0]   mode_o
);
    localparam int NBYTES = 2;

    // write decode
    always_comb begin
        lo_wr_o   = wr_en_i && (wr_addr_i == A_CNT_LO);
        ctrl_wr_o = wr_en_i && (wr_addr_i == A_CTRL);
        run_bit_o = wr_data_i[CTRL_RUN];
        clr_req_o = ctrl_wr_o && wr_data_i[CTRL_CLR];
    end

    // counter high-byte buffer
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_buf_o <= '0;
        end else if (wr_en_i && (wr_addr_i == A_CNT_HI)) begin
            hi_buf_o <= wr_data_i;
        end
    end

    // compare register, one byte lane per address
    for (genvar g = 0; g < NBYTES; g++) begin : g_cmp_lane
        localparam logic [2:0] LANE_ADDR = 3'(int'(A_CMP_LO) + g);
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                cmp_o[g*DW +: DW] <= '0;
            end else if (wr_en_i && (wr_addr_i == LANE_ADDR)) begin
                cmp_o[g*DW +: DW] <= wr_data_i;
            end
        end
    end

    // interrupt enable and mode field
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ie_o   <= 1'b0;
            mode_o <= '0;
        end else begin
            if (ctrl_wr_o) begin
                ie_o <= wr_data_i[CTRL_IE];
            end
            if (wr_en_i && (wr_addr_i == A_MODE)) begin
                mode_o <= wr_data_i[MODE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/tmr_ctl.sv
module tmr_ctl
    import tmr_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    ctrl_wr_i,
    input  logic    run_bit_i,
    input  logic    tick_i,
    input  logic    lo_wr_i,
    input  logic    fire_i,
    input  logic    at_max_i,
    output logic    step_o,
    output cnt_nx_e act_o
);
    run_st_e state, state_nx;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state <= ST_HALT;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: GO and STOP
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: if (ctrl_wr_i && run_bit_i)  state_nx = ST_RUN;
            ST_RUN:  if (ctrl_wr_i && !run_bit_i) state_nx = ST_HALT;
            default: state_nx = ST_HALT;
        endcase
    end

    // outputs: step qualifier and counter action by priority
    always_comb begin
        step_o = (state == ST_RUN) && tick_i;
        if (lo_wr_i) begin
            act_o = NX_LOAD;
        end else if (fire_i) begin
            act_o = NX_EVT;
        end else if (step_o && at_max_i) begin
            act_o = NX_WRAP;
        end else if (step_o) begin
            act_o = NX_STEP;
        end else begin
            act_o = NX_HOLD;
        end
    end

endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  cnt_nx_e       act_i,
    input  logic [CW-1:0] load_i,
    output logic [CW-1:0] count_o,
    output logic          at_max_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_o <= '0;
        end else begin
            unique case (act_i)
                NX_HOLD: count_o <= count_o;
                NX_STEP: count_o <= count_o + ONE;
                NX_WRAP: count_o <= '0;
                NX_EVT:  count_o <= '0;
                NX_LOAD: count_o <= load_i;
                default: count_o <= count_o;
            endcase
        end
    end

    assign at_max_o = &count_o;

endmodule

// File: rtl/tmr_evt.sv
module tmr_evt
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              step_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [CW-1:0]     cmp_i,
    input  logic [CW-1:0]     count_i,
    input  cnt_nx_e           act_i,
    input  logic              clr_req_i,
    input  logic              conv_en_i,
    output logic              fire_o,
    output logic              flag_o,
    output logic              trig_o,
    output logic              conv_start_o
);
    assign fire_o = step_i && (mode_i == MODE_SPECIAL) && (count_i == cmp_i);

    // sticky overflow flag: a set wins over a clear
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flag_o <= 1'b0;
        end else if (act_i == NX_WRAP) begin
            flag_o <= 1'b1;
        end else if (clr_req_i) begin
            flag_o <= 1'b0;
        end
    end

    // registered event pulses, aligned with the reset count
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            trig_o       <= 1'b0;
            conv_start_o <= 1'b0;
        end else begin
            trig_o       <= fire_o;
            conv_start_o <= fire_o && conv_en_i;
        end
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            tick_i,
    input  logic            conv_en_i,
    input  logic            wr_en_i,
    input  logic [2:0]      wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [2*DW-1:0] count_o,
    output logic            ovf_flag_o,
    output logic            irq_o,
    output logic            trig_o,
    output logic            conv_start_o
);
    localparam int CW = 2 * DW;

    logic              lo_wr, ctrl_wr, run_bit, clr_req, ie;
    logic              step, fire, at_max;
    logic [DW-1:0]     hi_buf;
    logic [CW-1:0]     cmp;
    logic [MODE_W-1:0] mode;
    cnt_nx_e           act;

    tmr_regs #(.DW(DW)) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .lo_wr_o   (lo_wr),
        .ctrl_wr_o (ctrl_wr),
        .run_bit_o (run_bit),
        .clr_req_o (clr_req),
        .ie_o      (ie),
        .hi_buf_o  (hi_buf),
        .cmp_o     (cmp),
        .mode_o    (mode)
    );

    tmr_ctl u_ctl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ctrl_wr_i (ctrl_wr),
        .run_bit_i (run_bit),
        .tick_i    (tick_i),
        .lo_wr_i   (lo_wr),
        .fire_i    (fire),
        .at_max_i  (at_max),
        .step_o    (step),
        .act_o     (act)
    );

    tmr_cnt #(.CW(CW)) u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .act_i    (act),
        .load_i   ({hi_buf, wr_data_i}),
        .count_o  (count_o),
        .at_max_o (at_max)
    );

    tmr_evt #(.CW(CW)) u_evt (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .step_i       (step),
        .mode_i       (mode),
        .cmp_i        (cmp),
        .count_i      (count_o),
        .act_i        (act),
        .clr_req_i    (clr_req),
        .conv_en_i    (conv_en_i),
        .fire_o       (fire),
        .flag_o       (ovf_flag_o),
        .trig_o       (trig_o),
        .conv_start_o (conv_start_o)
    );

    assign irq_o = ovf_flag_o && ie;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          step,
    input logic          fire,
    input logic          lo_wr,
    input logic          clr_req,
    input logic [DW-1:0] hi_buf,
    input logic [DW-1:0] wdata,
    input logic [CW-1:0] count,
    input logic          flag,
    input logic          trig,
    input logic          conv_start
);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !lo_wr) |=> $stable(count));

    // R3
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);

    // R5
    evt_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !lo_wr) |=> (count == '0) && trig);

    // R6
    evt_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !flag) |=> !flag);

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> (count == {$past(hi_buf), $past(wdata)}));

    // R8
    conv_pair_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> trig);

endmodule

bind cmp_timer tmr_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk        (clk_i),
    .rst        (rst_i),
    .step       (step),
    .fire       (fire),
    .lo_wr      (lo_wr),
    .clr_req    (clr_req),
    .hi_buf     (hi_buf),
    .wdata      (wr_data_i),
    .count      (count_o),
    .flag       (ovf_flag_o),
    .trig       (trig_o),
    .conv_start (conv_start_o)
);

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          conv = 1'b0;
    logic          we = 1'b0;
    logic [2:0]    wa = '0;
    logic [DW-1:0] wd = '0;
    logic [CW-1:0] count_o;
    logic          ovf_flag_o, irq_o, trig_o, conv_start_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer #(.DW(DW)) dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .tick_i       (tick),
        .conv_en_i    (conv),
        .wr_en_i      (we),
        .wr_addr_i    (wa),
        .wr_data_i    (wd),
        .count_o      (count_o),
        .ovf_flag_o   (ovf_flag_o),
        .irq_o        (irq_o),
        .trig_o       (trig_o),
        .conv_start_o (conv_start_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    int m_cnt, m_buf, m_cmp, m_mode, m_run, m_ie, m_flag, m_trig, m_adc;
    int trig_seen, adc_seen;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit st, lo, fire, wrap;
        st   = (m_run != 0) && tick;
        lo   = we && (wa == 3'd0);
        fire = st && (m_mode == 11) && (m_cnt == m_cmp);
        wrap = !lo && !fire && st && (m_cnt == 65535);
        if (rst) begin
            m_cnt = 0; m_buf = 0; m_cmp = 0; m_mode = 0; m_run = 0;
            m_ie = 0; m_flag = 0; m_trig = 0; m_adc = 0;
        end else begin
            m_trig = fire ? 1 : 0;
            m_adc  = (fire && conv) ? 1 : 0;
            if (lo)        m_cnt = m_buf * 256 + int'(wd);
            else if (fire) m_cnt = 0;
            else if (st)   m_cnt = (m_cnt + 1) % 65536;
            if (wrap) m_flag = 1;
            else if (we && wa == 3'd4 && wd[2]) m_flag = 0;
            if (we) begin
                case (wa)
                    3'd1: m_buf = int'(wd);
                    3'd2: m_cmp = (m_cmp & 'hFF00) | int'(wd);
                    3'd3: m_cmp = (m_cmp & 'h00FF) | (int'(wd) * 256);
                    3'd4: begin m_run = int'(wd[0]); m_ie = int'(wd[1]); end
                    3'd5: m_mode = int'(wd[3:0]);
                    default: ;
                endcase
            end
        end
    endtask

    task automatic compare_all();
        check("R2", "count", int'(count_o), m_cnt);
        check("R3", "overflow flag", int'(ovf_flag_o), m_flag);
        check("R4", "irq", int'(irq_o), (m_flag != 0 && m_ie != 0) ? 1 : 0);
        check("R5", "trigger", int'(trig_o), m_trig);
        check("R8", "converter start", int'(conv_start_o), m_adc);
        trig_seen += int'(trig_o);
        adc_seen  += int'(conv_start_o);
    endtask

    task automatic cyc(input bit w, input int a, input int d, input bit t);
        we = w; wa = a[2:0]; wd = d[7:0]; tick = t;
        @(posedge clk);
        model_step();
        #(CLK_PERIOD/4);
        compare_all();
        we = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic idle(input int n, input bit t);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, t);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        idle(3, 1'b0);
        rst = 1'b0;
        // R1 reset state
        check("R1", "count after reset", int'(count_o), 0);
        check("R1", "flag after reset", int'(ovf_flag_o), 0);
        check("R1", "pulses after reset", int'(trig_o | conv_start_o | irq_o), 0);
        idle(2, 1'b1);
        check("R11", "halted after reset", int'(count_o), 0);

        // R9 two-byte load
        wr(1, 'h12); wr(0, 'h34);
        check("R9", "two-byte load", int'(count_o), 'h1234);

        // R11 GO, R2 counting with gaps
        wr(4, 1);
        idle(5, 1'b1);
        check("R2", "five steps", int'(count_o), 'h1239);
        idle(3, 1'b0);
        check("R2", "no tick holds", int'(count_o), 'h1239);
        wr(4, 0);
        idle(4, 1'b1);
        check("R11", "STOP ignores ticks", int'(count_o), 'h1239);

        // R3/R4 wrap, flag, irq
        wr(1, 'hFF); wr(0, 'hFE); wr(4, 'b011);
        idle(2, 1'b1);
        check("R3", "wrap sets flag", int'(ovf_flag_o), 1);
        check("R4", "irq with enable", int'(irq_o), 1);
        idle(3, 1'b1);
        wr(4, 'b001);
        check("R4", "irq masked", int'(irq_o), 0);
        check("R3", "flag sticky", int'(ovf_flag_o), 1);
        wr(4, 'b101);
        check("R3", "flag cleared", int'(ovf_flag_o), 0);
        wr(1, 'hFF); wr(0, 'hFF);
        cyc(1'b1, 4, 'b101, 1'b1);
        check("R3", "set wins over clear", int'(ovf_flag_o), 1);
        check("R3", "wrapped count", int'(count_o), 0);
        wr(4, 'b101);

        // R5/R8 period via compare
        wr(2, 5); wr(3, 0); wr(5, 'hB); wr(1, 0); wr(0, 0);
        conv = 1'b1;
        trig_seen = 0; adc_seen = 0;
        idle(20, 1'b1);
        check("R5", "three periods of six", trig_seen, 3);
        check("R8", "start pulses with enable", adc_seen, 3);
        check("R5", "count after 20 steps", int'(count_o), 2);
        conv = 1'b0;
        trig_seen = 0; adc_seen = 0;
        idle(6, 1'b1);
        check("R8", "no start when disabled", adc_seen, 0);
        check("R5", "trigger still fires", trig_seen, 1);

        // R10 other mode
        wr(5, 'hA); wr(0, 0);
        idle(10, 1'b1);
        check("R10", "no reset in other mode", int'(count_o), 10);

        // R6 match at top value
        wr(2, 'hFF); wr(3, 'hFF); wr(5, 'hB); wr(1, 'hFF); wr(0, 'hFE);
        idle(2, 1'b1);
        check("R6", "match at top keeps flag clear", int'(ovf_flag_o), 0);
        check("R6", "match at top resets", int'(count_o), 0);

        // R7 write wins over match and wrap
        wr(2, 5); wr(3, 0); wr(1, 0); wr(0, 5);
        cyc(1'b1, 0, 'h40, 1'b1);
        check("R7", "write over match", int'(count_o), 'h40);
        wr(5, 0); wr(1, 'hFF); wr(0, 'hFF);
        cyc(1'b1, 0, 'h22, 1'b1);
        check("R7", "write over wrap", int'(count_o), 'hFF22);
        check("R7", "no flag on write over wrap", int'(ovf_flag_o), 0);
        wr(0, 'h01);
        check("R9", "buffer retained", int'(count_o), 'hFF01);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule